// File: doc/BRIEF.md
# Slow-Clock Timekeeping Counter with Compare Alarm

The block keeps time in the always-on domain. A counter of `CNT_W` bits (48 by default) runs freely on the slow clock. It moves forward by two once in every two slow-clock cycles and wraps around at 2^CNT_W. No port can load or modify the count. The count is kept as it is when the clock that drives the block changes source. Any conversion of the count into time units is done outside the block.

Software reads the count through a snapshot. A one-cycle request captures the value the counter takes at its next update. The snapshot is presented together with a valid flag, so a read can take up to one update period. Software also writes a target value. When the alarm is enabled and the counter equals the target, the block emits a single pulse that can serve as a wakeup source. The alarm fires once for each write of the target.

Top module: `rtc_counter_top`

## Requirements
- R1: While rst_ni is low and after it is released, the count is zero, snap_valid_o and alarm_o are low, and the alarm is disarmed.
- R2: The count stays fixed for one cycle and then increases by 2 on the next, so two snapshots requested N cycles apart (N even) differ by N.
- R3: The count wraps modulo 2^CNT_W: an 8-bit instance reads the main count modulo 256.
- R4: A snapshot holds the count value produced by the first counter update at or after the clock edge that samples snap_req_i. Its value is visible one clock after that update.
- R5: A request that no update serves in the same edge drops snap_valid_o in the following cycle. snap_valid_o rises when the capture happens, and snap_o keeps its value until the next capture.
- R6: alarm_o is a one-cycle pulse. It is raised the cycle after an edge at which the alarm is armed, alarm_en_i is high and the count equals the stored target.
- R7: After a pulse the alarm stays disarmed, so it does not fire again until target_we_i writes a new target.
- R8: While alarm_en_i is low no pulse is produced. An armed alarm whose match passes while disabled stays silent.
- R9: A cycle with target_we_i high stores target_i, arms the alarm and produces no pulse in the following cycle.
- R10: An odd target never matches, because the count is always even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snap_req_i | input | 1 | Snapshot request, one cycle |
| target_i | input | CNT_W | Alarm compare value |
| target_we_i | input | 1 | Stores target_i and arms the alarm |
| alarm_en_i | input | 1 | Alarm enable |
| snap_o | output | CNT_W | Captured count |
| snap_valid_o | output | 1 | snap_o holds a completed capture |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
The assertions assume that every input is synchronous to clk_i and settles away from the rising edge. They also assume the update period is the default of two cycles, which the latency property depends on. The bench drives all inputs on the falling edge and keeps the default period. A narrow 8-bit instance runs beside the main one on the same stimulus. It reaches wrap-around within a short run, and that run stays well within the assumed conditions.

// File: rtl/rtc_cnt_pkg.sv
package rtc_cnt_pkg;
  localparam int unsigned DEF_CNT_W = 48;
  localparam int unsigned DEF_DIV   = 2;
  localparam int unsigned DEF_STEP  = 2;

  typedef enum logic [1:0] {
    SNAP_IDLE  = 2'd0,
    SNAP_PEND  = 2'd1,
    SNAP_VALID = 2'd2
  } snap_state_e;
endpackage

// File: rtl/rtc_tick.sv
module rtc_tick #(
  parameter int unsigned CNT_W = rtc_cnt_pkg::DEF_CNT_W,
  parameter int unsigned DIV   = rtc_cnt_pkg::DEF_DIV,
  parameter int unsigned STEP  = rtc_cnt_pkg::DEF_STEP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             adv_o
);
  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] cnt_q;

  assign adv_o = (ph_q == PH_LAST);
  assign nxt_o = cnt_q + CNT_W'(STEP);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      cnt_q <= '0;
    end else if (adv_o) begin
      ph_q  <= '0;
      cnt_q <= nxt_o;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_snap.sv
module rtc_snap #(
  parameter int unsigned CNT_W = rtc_cnt_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             valid_o
);
  import rtc_cnt_pkg::*;

  snap_state_e      st_q, st_d;
  logic [CNT_W-1:0] snap_q;
  logic             take;

  // capture on the update edge if a request is present or waiting
  assign take = adv_i && (req_i || st_q == SNAP_PEND);

  always_comb begin
    st_d = st_q;
    if (take)       st_d = SNAP_VALID;
    else if (req_i) st_d = SNAP_PEND;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SNAP_IDLE;
      snap_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) snap_q <= nxt_i;
    end
  end

  assign snap_o  = snap_q;
  assign valid_o = (st_q == SNAP_VALID);
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned CNT_W = rtc_cnt_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] tgt_i,
  input  logic             we_i,
  input  logic             en_i,
  output logic             alarm_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] tgt_q;
  logic             armed_q;
  logic             hit_q;
  logic             fire;

  assign fire = armed_q && en_i && !we_i && (cnt_i == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= '0;
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= fire;
      if (we_i) begin
        tgt_q   <= tgt_i;
        armed_q <= 1'b1;
      end else if (fire) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign alarm_o = hit_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/rtc_counter_top.sv
module rtc_counter_top #(
  parameter int unsigned CNT_W = rtc_cnt_pkg::DEF_CNT_W,
  parameter int unsigned DIV   = rtc_cnt_pkg::DEF_DIV,
  parameter int unsigned STEP  = rtc_cnt_pkg::DEF_STEP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snap_req_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic             target_we_i,
  input  logic             alarm_en_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             snap_valid_o,
  output logic             alarm_o
);
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] nxt_w;
  logic             adv_w;
  logic             armed_w;

  rtc_tick #(.CNT_W(CNT_W), .DIV(DIV), .STEP(STEP)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_w),
    .nxt_o  (nxt_w),
    .adv_o  (adv_w)
  );

  rtc_snap #(.CNT_W(CNT_W)) u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (snap_req_i),
    .adv_i   (adv_w),
    .nxt_i   (nxt_w),
    .snap_o  (snap_o),
    .valid_o (snap_valid_o)
  );

  rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_w),
    .tgt_i   (target_i),
    .we_i    (target_we_i),
    .en_i    (alarm_en_i),
    .alarm_o (alarm_o),
    .armed_o (armed_w)
  );
endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk #(
  parameter int unsigned CNT_W = rtc_cnt_pkg::DEF_CNT_W,
  parameter int unsigned STEP  = rtc_cnt_pkg::DEF_STEP
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             snap_req_i,
  input logic             target_we_i,
  input logic             alarm_en_i,
  input logic [CNT_W-1:0] cnt,
  input logic             adv,
  input logic             armed,
  input logic [CNT_W-1:0] snap,
  input logic             snap_valid,
  input logic             alarm
);
  a_r1_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> !alarm && !snap_valid);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> cnt == $past(cnt) + CNT_W'(STEP));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(cnt));

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_req_i ##1 !snap_valid |=> snap_valid);

  a_r5_hold_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(snap));

  a_r6_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm |=> !alarm);

  a_r7_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm |-> !armed);

  a_r8_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_en_i |=> !alarm);

  a_r9_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_we_i |=> !alarm && armed);

  a_r10_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt[0]);
endmodule

bind rtc_counter_top rtc_counter_chk #(.CNT_W(CNT_W), .STEP(STEP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .snap_req_i  (snap_req_i),
  .target_we_i (target_we_i),
  .alarm_en_i  (alarm_en_i),
  .cnt         (cnt_w),
  .adv         (adv_w),
  .armed       (armed_w),
  .snap        (snap_o),
  .snap_valid  (snap_valid_o),
  .alarm       (alarm_o)
);

// File: tb/rtc_counter_top_tb_top.sv
module rtc_counter_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snap_req = 1'b0;
  logic target_we = 1'b0;
  logic alarm_en = 1'b0;
  logic [47:0] target = '0;

  logic [47:0] snap0;
  logic [NW-1:0] snap1;
  logic v0, v1, al0, al1;

  int errors = 0;
  int checks = 0;
  int pulses0 = 0;
  int pulses1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_counter_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .snap_req_i(snap_req), .target_i(target),
    .target_we_i(target_we), .alarm_en_i(alarm_en),
    .snap_o(snap0), .snap_valid_o(v0), .alarm_o(al0));

  rtc_counter_top #(.CNT_W(NW)) dut_n (
    .clk_i(clk), .rst_ni(rst_n), .snap_req_i(snap_req), .target_i(target[NW-1:0]),
    .target_we_i(target_we), .alarm_en_i(alarm_en),
    .snap_o(snap1), .snap_valid_o(v1), .alarm_o(al1));

  // behavioural reference, index 0 = 48-bit, 1 = narrow
  longint m_mask [2];
  longint m_cnt [2];
  longint m_snap [2];
  longint m_tgt [2];
  int     m_age;
  bit     m_pend [2];
  bit     m_valid [2];
  bit     m_armed [2];
  bit     m_alarm [2];

  initial begin
    m_mask[0] = (64'd1 << 48) - 1;
    m_mask[1] = (64'd1 << NW) - 1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_age = 0;
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_snap[k] = 0; m_tgt[k] = 0;
        m_pend[k] = 0; m_valid[k] = 0; m_armed[k] = 0; m_alarm[k] = 0;
      end
    end else begin
      bit up;
      up = (m_age % 2) == 1;
      for (int k = 0; k < 2; k++) begin
        longint nc;
        nc = up ? ((m_cnt[k] + 2) & m_mask[k]) : m_cnt[k];
        m_alarm[k] = 0;
        if (target_we) begin
          m_tgt[k] = longint'(target) & m_mask[k];
          m_armed[k] = 1;
        end else if (m_armed[k] && alarm_en && m_cnt[k] == m_tgt[k]) begin
          m_alarm[k] = 1;
          m_armed[k] = 0;
        end
        if (up && (snap_req || m_pend[k])) begin
          m_snap[k] = nc; m_valid[k] = 1; m_pend[k] = 0;
        end else if (snap_req) begin
          m_valid[k] = 0; m_pend[k] = 1;
        end
        m_cnt[k] = nc;
      end
      m_age++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(v0 == m_valid[0], "R5 valid", v0, m_valid[0]);
      chk(v1 == m_valid[1], "R5 valid narrow", v1, m_valid[1]);
      if (m_valid[0]) chk(longint'(snap0) == m_snap[0], "R4 snap", snap0, m_snap[0]);
      if (m_valid[1]) chk(longint'(snap1) == m_snap[1], "R3 snap narrow", snap1, m_snap[1]);
      chk(al0 == m_alarm[0], "R6 alarm", al0, m_alarm[0]);
      chk(al1 == m_alarm[1], "R6 alarm narrow", al1, m_alarm[1]);
      if (al0) pulses0++;
      if (al1) pulses1++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req_pulse();
    snap_req = 1'b1; step(1); snap_req = 1'b0;
  endtask

  task automatic read(output longint v);
    req_pulse();
    for (int i = 0; i < 4 && !v0; i++) step(1);
    v = longint'(snap0);
  endtask

  task automatic write_tgt(input longint t, input bit en);
    target = t[47:0]; alarm_en = en; target_we = 1'b1; step(1); target_we = 1'b0;
  endtask

  initial begin
    longint a, b, c;
    int p0;
    step(3);
    chk(!v0 && !al0, "R1 in reset", {v0, al0}, 0);
    rst_n = 1'b1;
    step(3);
    chk(!v0 && !al0 && !v1 && !al1, "R1 after reset", {v0, al0}, 0);

    // snapshots at varied phases
    for (int g = 1; g <= 6; g++) begin req_pulse(); step(g); end

    // R2: requests 10 cycles apart differ by 10
    req_pulse(); step(3); a = longint'(snap0);
    step(6);
    req_pulse(); step(3); b = longint'(snap0);
    chk(b - a == 10, "R2 step", b - a, 10);
    chk(a[0] == 1'b0, "R10 even count", a[0], 0);

    // R6/R7: single pulse per write
    read(c);
    p0 = pulses0;
    write_tgt(c + 20, 1'b1);
    step(60);
    chk(pulses0 - p0 == 1, "R7 single pulse", pulses0 - p0, 1);

    // R10: odd target never fires
    read(c); p0 = pulses0;
    write_tgt(c + 21, 1'b1);
    step(60);
    chk(pulses0 == p0, "R10 odd target", pulses0 - p0, 0);

    // R8: disabled alarm passes its match silently, then stays quiet when enabled
    read(c); p0 = pulses0;
    write_tgt(c + 16, 1'b0);
    step(40);
    alarm_en = 1'b1;
    step(40);
    chk(pulses0 == p0, "R8 disabled", pulses0 - p0, 0);

    // R9: write target equal to the current count, every cycle for a while
    read(c); p0 = pulses0;
    for (int i = 0; i < 6; i++) begin
      target = c[47:0]; target_we = 1'b1; step(1);
      chk(!al0, "R9 no pulse during writes", al0, 0);
    end
    target_we = 1'b0;
    step(30);

    // R3: run past the narrow wrap and compare
    step(300);
    read(a);
    step(1);
    chk(longint'(snap1) == (a & 255), "R3 wrap", snap1, a & 255);
    chk(a > 255, "R3 beyond wrap", a, 256);

    // R1: mid-run reset clears everything
    rst_n = 1'b0; step(2);
    chk(!v0 && !al0, "R1 mid reset", v0, 0);
    rst_n = 1'b1; step(1);
    read(a);
    chk(a <= 4, "R1 count restarts", a, 2);
    step(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule